// File: doc/BRIEF.md
# UART Modem Status Register Logic

This block forms the modem-status part of a UART. It takes four active-low modem lines from the outside world (carrier detect, ring indicator, data set ready, clear to send), brings them into the clock domain through a short synchroniser chain, and shows them to software as active-high level bits in a 32-bit read-only register. Beside each level it keeps a sticky change flag. Reading the register clears these flags. An enabled modem-status interrupt is raised while any flag is set.

In loopback mode the four level bits ignore the pins. They take their values from four modem-control outputs of the same UART instead: carrier detect follows auxiliary output 2, ring follows auxiliary output 1, data set ready follows terminal ready, and clear to send follows request to send. Change detection works on the selected source. Software can therefore test the whole status and interrupt path by toggling its own control outputs.

The ring flag differs from the other three. It records only the moment the ring pin goes inactive (pin 0 to 1). It does not record every change.

Top module: `modem_status_reg`

## Requirements
- R1: `rdata` is 32 bits wide, bits 31:8 always read 0, and every bit reads 0 after reset with the pins inactive (high).
- R2: Outside loopback, `rdata[7]`, `rdata[6]`, `rdata[5]` and `rdata[4]` are the inverse of `carrier_n`, `ring_n`, `set_ready_n` and `clr_send_n`. A pin change appears after two rising clock edges of synchronisation.
- R3: With `loop_en` = 1, `rdata[7:4]` equals {`lb_aux2`, `lb_aux1`, `lb_term_rdy`, `lb_req_send`}, and the pins have no effect on any register bit.
- R4: `rdata[3]`, `rdata[1]` and `rdata[0]` set one edge after the selected carrier, data-set-ready or clear-to-send level changes in either direction, and stay set until a read.
- R5: `rdata[2]` sets only when the ring level bit goes from 1 to 0 (the pin going 0 to 1). A 0-to-1 change of the ring level bit leaves it unchanged.
- R6: A cycle with `rd_stb` = 1 clears bits 3:0 at the next edge. A change detected at that same edge keeps its flag set.
- R7: `irq` is 1 exactly when `int_en` = 1 and any of `rdata[3:0]` is 1, with no register delay.
- R8: In loopback, a change of a control input sets its change flag at the next rising edge. Entering loopback is itself detected as a change of every level that differs between pin and control source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carrier_n | input | 1 | Carrier detect pin, active low, asynchronous |
| ring_n | input | 1 | Ring indicator pin, active low, asynchronous |
| set_ready_n | input | 1 | Data set ready pin, active low, asynchronous |
| clr_send_n | input | 1 | Clear to send pin, active low, asynchronous |
| loop_en | input | 1 | Loopback select |
| lb_aux2 | input | 1 | Auxiliary control output 2, loopback source for carrier |
| lb_aux1 | input | 1 | Auxiliary control output 1, loopback source for ring |
| lb_term_rdy | input | 1 | Terminal ready control output, loopback source for data set ready |
| lb_req_send | input | 1 | Request to send control output, loopback source for clear to send |
| rd_stb | input | 1 | One-cycle register read strobe |
| int_en | input | 1 | Modem-status interrupt enable |
| rdata | output | 32 | Register read value |
| irq | output | 1 | Modem-status interrupt |

## Verification
The embedded properties check these on every cycle:
- the loopback mapping;
- that a detected level change always leaves its flag set;
- that a ring-level rise never sets the trailing-edge flag;
- that a read with no coincident change empties the flags;
- that an interrupt never appears without a flag.

Only the bench's scenarios can show the two-edge latency through the synchroniser, pins being ignored in loopback, and the case where a read and a change meet in the same cycle. They also show the interrupt following the enable and the trailing-ring flag recording a pin release but not an assertion.

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 32,
  parameter int LINES       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carrier_n,
  input  logic             ring_n,
  input  logic             set_ready_n,
  input  logic             clr_send_n,
  input  logic             loop_en,
  input  logic             lb_aux2,
  input  logic             lb_aux1,
  input  logic             lb_term_rdy,
  input  logic             lb_req_send,
  input  logic             rd_stb,
  input  logic             int_en,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);
  localparam int PAD_W   = REG_W - 2*LINES;
  localparam int LAST    = SYNC_STAGES - 1;
  localparam int RING_IX = LINES - 2;

  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] lvl, lvl_q, evt, delta_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q[0] <= '1;
    else        sync_q[0] <= {carrier_n, ring_n, set_ready_n, clr_send_n};

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[s] <= '1;
      else        sync_q[s] <= sync_q[s-1];
  end

  assign lvl = loop_en ? {lb_aux2, lb_aux1, lb_term_rdy, lb_req_send} : ~sync_q[LAST];

  for (genvar i = 0; i < LINES; i++) begin : g_evt
    if (i == RING_IX) begin : g_trail
      assign evt[i] = lvl_q[i] & ~lvl[i];
    end else begin : g_any
      assign evt[i] = lvl_q[i] ^ lvl[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lvl;
      delta_q <= (rd_stb ? '0 : delta_q) | evt;
    end

  assign rdata = {{PAD_W{1'b0}}, lvl, delta_q};
  assign irq   = int_en & (|delta_q);

  // R3
  loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> rdata[7:4] == {lb_aux2, lb_aux1, lb_term_rdy, lb_req_send});

  // R4
  change_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != lvl_q) && !(lvl_q[RING_IX] == 1'b0 && lvl[RING_IX] == 1'b1 && (lvl ^ lvl_q) == (LINES'(1) << RING_IX))
    |=> ((rdata[LINES-1:0] & $past(evt)) == $past(evt)) && ($past(evt) != '0));

  // R5
  ring_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!delta_q[RING_IX] && !lvl_q[RING_IX] && lvl[RING_IX]) |=> !rdata[RING_IX]);

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && lvl == lvl_q) |=> rdata[LINES-1:0] == '0);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (rdata[LINES-1:0] & $past(delta_q)) == $past(delta_q));

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_en && rdata[3:0] != 4'b0));
endmodule

// File: tb/modem_status_reg_tb.sv
module modem_status_reg_tb;
  logic clk = 0, rst_n = 0;
  logic carrier_n = 1, ring_n = 1, set_ready_n = 1, clr_send_n = 1;
  logic loop_en = 0, lb_aux2 = 0, lb_aux1 = 0, lb_term_rdy = 0, lb_req_send = 0;
  logic rd_stb = 0, int_en = 0;
  logic [31:0] rdata;
  logic irq;

  always #4 clk = ~clk;

  modem_status_reg u_dut (.*);

  typedef struct { logic [31:0] val; logic irq; string req; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic expect_now(input logic [31:0] v, input logic i, input string req);
    item_t it;
    it.val = v; it.irq = i; it.req = req;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1;
    edges(1);
    rd_stb = 0;
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      wait (sb_q.size() != 0);
      #1;
      it = sb_q[0];
      n_cmp++;
      if (rdata !== it.val || irq !== it.irq) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", it.req, rdata, irq, it.val, it.irq);
      end
      void'(sb_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    edges(3);
    rst_n = 1;
    edges(1);
    expect_now(32'h0, 0, "R1 reset");
    clr_send_n = 0; edges(3);
    expect_now(32'h11, 0, "R2 R4 cts assert, irq masked (R7)");
    do_read();
    expect_now(32'h10, 0, "R6 read clears");
    int_en = 1;
    set_ready_n = 0; edges(1);
    expect_now(32'h10, 0, "R2 one edge not yet visible");
    edges(2);
    expect_now(32'h32, 1, "R4 R7 dsr change raises irq");
    do_read();
    expect_now(32'h30, 0, "R7 irq drops after read");
    ring_n = 0; edges(3);
    expect_now(32'h70, 0, "R5 ring assert no flag");
    ring_n = 1; edges(3);
    expect_now(32'h34, 1, "R5 ring release sets trailing flag");
    do_read();
    expect_now(32'h30, 0, "R6 clear after ring");
    carrier_n = 0; edges(3);
    expect_now(32'hB8, 1, "R4 carrier assert");
    carrier_n = 1; edges(3);
    expect_now(32'h38, 1, "R4 flag sticky after release");
    do_read();
    expect_now(32'h30, 0, "R6 clear after carrier");
    clr_send_n = 1; edges(2);
    rd_stb = 1; edges(1); rd_stb = 0;
    expect_now(32'h21, 1, "R6 coincident change wins");
    do_read();
    expect_now(32'h20, 0, "R6 clear after coincident");
    loop_en = 1; edges(1);
    expect_now(32'h02, 1, "R8 entering loopback detected");
    do_read();
    expect_now(32'h00, 0, "R3 loopback levels from controls");
    carrier_n = 0; ring_n = 0; clr_send_n = 0; set_ready_n = 1; edges(4);
    expect_now(32'h00, 0, "R3 pins ignored in loopback");
    lb_aux2 = 1; edges(1);
    expect_now(32'h88, 1, "R8 R3 aux2 to carrier");
    do_read();
    lb_aux1 = 1; edges(1);
    expect_now(32'hC0, 0, "R5 R3 aux1 set no trailing flag");
    lb_aux1 = 0; edges(1);
    expect_now(32'h84, 1, "R5 R8 aux1 clear trailing flag");
    do_read();
    lb_term_rdy = 1; edges(1);
    expect_now(32'hA2, 1, "R8 R3 terminal ready to dsr");
    do_read();
    lb_req_send = 1; edges(1);
    expect_now(32'hB1, 1, "R8 R3 request to cts");
    int_en = 0;
    expect_now(32'hB1, 0, "R7 irq follows enable at once");
    do_read();
    expect_now(32'hB0, 0, "R1 R6 upper bits zero, cleared");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule